// File: doc/BRIEF.md
# Firmware Image Upload and Checksum Engine

This block is the host-side engine that copies a plug-in module's firmware image across a byte-wide I/O bus into local memory and decides whether the copy is good. For each image byte, the engine does three bus operations. It first writes the byte index into the module's address registers, low byte first and then high byte. It then reads the byte back from the module's data port. Every byte read is forwarded at once to a destination memory write port, at a configurable base address plus the byte index.

The image describes its own size. Its first two bytes hold the total length, least significant byte first. That length counts the two length bytes, the payload and the two checksum bytes at the end. The engine keeps a 16-bit running sum of every byte except the final two. It then adds the trailing 16-bit checksum, and the image is good when the result is zero.

On a good image, the engine writes the upload-complete flag into the module's control port. It then pulses `done` with `pass` high. A length that is too short or too long stops the transfer after the two length bytes, and no flag is written. A checksum mismatch also gives a fail result with no flag write.

Top module: `upl_engine`

## Requirements
- R1: For byte index i, counting up from 0, the engine writes i[7:0] to port 8'h13, then i[15:8] to port 8'h14, then reads port 8'h11; these three operations never reorder.
- R2: A strobe (`bus_wr` or `bus_rd`) together with its address and write data stays unchanged until a cycle in which `bus_rdy` is high, and that cycle completes the operation. `bus_wr` and `bus_rd` are never high together.
- R3: In the cycle in which a read of byte i completes, `mem_we` is high, `mem_addr` equals MEM_BASE (default 16'h7020) plus i, and `mem_wdata` equals `bus_rdata`.
- R4: The image length is byte 0 (low) and byte 1 (high). For a valid length L, exactly L bytes, indices 0 to L-1, are read and stored.
- R5: If L < 4 or L > MAX_LEN, the engine reads only bytes 0 and 1. It then pulses `done` with `pass` low and writes nothing to port 8'h10.
- R6: With a valid length, the image passes when, modulo 2^16, the sum of bytes 0 to L-3 plus the checksum {byte L-1, byte L-2} equals zero; sums above 16 bits wrap.
- R7: On a pass, the engine writes 8'h02 (only bit 1 set, the upload flag) to port 8'h10 once, before `done`. On a fail, it makes no write to port 8'h10.
- R8: `done` is high for exactly one cycle per accepted start. `pass` is valid in that cycle and holds until the next accepted start.
- R9: A `start` pulse that arrives while a transfer is in progress is ignored and does not disturb the running transfer.
- R10: After reset, `bus_wr`, `bus_rd`, `mem_we` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an upload when idle |
| bus_addr | output | 8 | I/O port address |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data from the module |
| bus_rdy | input | 1 | Completes the current operation when high |
| mem_we | output | 1 | Destination memory write enable |
| mem_addr | output | MEM_AW | Destination memory address |
| mem_wdata | output | 8 | Destination memory write data |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result: 1 good image, 0 rejected |

## Verification
The assertions assume two things about the inputs. First, `bus_rdata` is valid in any cycle in which a read strobe meets `bus_rdy`. Second, `bus_rdy` eventually rises, so that the hold-until-ready check has a finite window to track. The stimulus obeys both rules. A model of the module returns the image byte selected by its last two address writes. The model drives `bus_rdy` low only in a fixed pattern of wait cycles, and it drives it one time step after the clock edge. Images are built with lengths at and beyond both bounds, with correct and corrupted checksums, and with a run of 8'hFF bytes long enough to wrap the 16-bit sum.

// File: rtl/upl_pkg.sv
package upl_pkg;
   localparam int BYTE_W = 8;
   localparam int IMG_AW = 16;   // two address bytes per image index

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ALO,
      ST_AHI,
      ST_RD,
      ST_CHK,
      ST_FLAG,
      ST_FIN
   } upl_state_e;
endpackage

// File: rtl/upl_sum.sv
module upl_sum
   import upl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              byte_v,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic [IMG_AW-1:0] idx,
   input  logic [IMG_AW-1:0] len,
   output logic              sum_ok
);
   logic [IMG_AW-1:0] acc;
   logic [BYTE_W-1:0] chk_lo, chk_hi;
   logic [IMG_AW-1:0] total;
   logic              in_body;

   // bytes 0 and 1 always belong to the summed body (length >= 4)
   assign in_body = (idx < IMG_AW'(2)) || (idx < (len - IMG_AW'(2)));
   assign total   = acc + {chk_hi, chk_lo};
   assign sum_ok  = (total == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc    <= '0;
         chk_lo <= '0;
         chk_hi <= '0;
      end else if (clr) begin
         acc    <= '0;
         chk_lo <= '0;
         chk_hi <= '0;
      end else if (byte_v) begin
         if (in_body)
            acc <= acc + IMG_AW'(byte_in);
         else if (idx == len - IMG_AW'(2))
            chk_lo <= byte_in;
         else
            chk_hi <= byte_in;
      end
   end

   AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_v && idx >= IMG_AW'(2)) |-> (idx < len)); // R4
endmodule

// File: rtl/upl_ctl.sv
module upl_ctl
   import upl_pkg::*;
#(
   parameter int                MAX_LEN   = 4096,
   parameter int                MEM_AW    = 16,
   parameter logic [MEM_AW-1:0] MEM_BASE  = 16'h7020,
   parameter logic [7:0]        PORT_ALO  = 8'h13,
   parameter logic [7:0]        PORT_AHI  = 8'h14,
   parameter logic [7:0]        PORT_DAT  = 8'h11,
   parameter logic [7:0]        PORT_CTL  = 8'h10,
   parameter int                FLAG_BIT  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              bus_rdy,
   input  logic [BYTE_W-1:0] bus_rdata,
   input  logic              sum_ok,
   output logic [7:0]        bus_addr,
   output logic              bus_wr,
   output logic              bus_rd,
   output logic [BYTE_W-1:0] bus_wdata,
   output logic              mem_we,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [BYTE_W-1:0] mem_wdata,
   output logic              byte_v,
   output logic              clr,
   output logic [IMG_AW-1:0] idx,
   output logic [IMG_AW-1:0] len,
   output logic              done,
   output logic              pass
);
   localparam logic [BYTE_W-1:0] FLAG_VAL = BYTE_W'(1) << FLAG_BIT;

   upl_state_e        st, st_nx;
   logic [IMG_AW-1:0] hdr_len;
   logic              len_short, len_long, len_bad, last_byte;

   assign hdr_len   = {bus_rdata, len[BYTE_W-1:0]};
   assign len_short = (hdr_len < IMG_AW'(4));

   generate
      if (MAX_LEN >= 65535) begin : g_nolimit
         assign len_long = 1'b0;
      end else begin : g_limit
         assign len_long = (hdr_len > IMG_AW'(MAX_LEN));
      end
   endgenerate

   assign len_bad   = len_short || len_long;
   assign last_byte = (idx >= IMG_AW'(2)) && (idx == len - IMG_AW'(1));

   always_comb begin
      st_nx     = st;
      bus_addr  = '0;
      bus_wr    = 1'b0;
      bus_rd    = 1'b0;
      bus_wdata = '0;
      byte_v    = 1'b0;
      clr       = 1'b0;
      done      = 1'b0;
      unique case (st)
         ST_IDLE: if (start) begin
            clr   = 1'b1;
            st_nx = ST_ALO;
         end
         ST_ALO: begin
            bus_wr    = 1'b1;
            bus_addr  = PORT_ALO;
            bus_wdata = idx[BYTE_W-1:0];
            if (bus_rdy) st_nx = ST_AHI;
         end
         ST_AHI: begin
            bus_wr    = 1'b1;
            bus_addr  = PORT_AHI;
            bus_wdata = idx[IMG_AW-1:BYTE_W];
            if (bus_rdy) st_nx = ST_RD;
         end
         ST_RD: begin
            bus_rd   = 1'b1;
            bus_addr = PORT_DAT;
            if (bus_rdy) begin
               byte_v = 1'b1;
               if (idx == IMG_AW'(1) && len_bad) st_nx = ST_FIN;
               else if (last_byte)               st_nx = ST_CHK;
               else                              st_nx = ST_ALO;
            end
         end
         ST_CHK:  st_nx = sum_ok ? ST_FLAG : ST_FIN;
         ST_FLAG: begin
            bus_wr    = 1'b1;
            bus_addr  = PORT_CTL;
            bus_wdata = FLAG_VAL;
            if (bus_rdy) st_nx = ST_FIN;
         end
         ST_FIN: begin
            done  = 1'b1;
            st_nx = ST_IDLE;
         end
         default: st_nx = ST_IDLE;
      endcase
   end

   assign mem_we    = byte_v;
   assign mem_wdata = bus_rdata;
   assign mem_addr  = MEM_BASE + MEM_AW'(idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         idx  <= '0;
         len  <= '0;
         pass <= 1'b0;
      end else begin
         st <= st_nx;
         if (clr) begin
            idx  <= '0;
            len  <= '0;
            pass <= 1'b0;
         end
         if (byte_v) begin
            if (idx == IMG_AW'(0)) len[BYTE_W-1:0]      <= bus_rdata;
            if (idx == IMG_AW'(1)) len[IMG_AW-1:BYTE_W] <= bus_rdata;
            if (st_nx == ST_ALO)   idx <= idx + IMG_AW'(1);
         end
         if (st == ST_CHK && sum_ok) pass <= 1'b1;
      end
   end

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_rd)); // R2
   AST_HOLD_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_rdy) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata))); // R2
   AST_HOLD_RD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_rdy) |=> (bus_rd && $stable(bus_addr))); // R2
   AST_MEM_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (bus_rd && bus_rdy && bus_addr == PORT_DAT)); // R3
   AST_FLAG_ONLY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == PORT_CTL) |-> sum_ok); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
endmodule

// File: rtl/upl_engine.sv
module upl_engine
   import upl_pkg::*;
#(
   parameter int                MAX_LEN  = 4096,
   parameter int                MEM_AW   = 16,
   parameter logic [MEM_AW-1:0] MEM_BASE = 16'h7020,
   parameter int                FLAG_BIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic [7:0]        bus_addr,
   output logic              bus_wr,
   output logic              bus_rd,
   output logic [7:0]        bus_wdata,
   input  logic [7:0]        bus_rdata,
   input  logic              bus_rdy,
   output logic              mem_we,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              done,
   output logic              pass
);
   generate
      if (MAX_LEN < 4)
         $error("MAX_LEN must be at least 4");
      if (MAX_LEN > 65535)
         $error("MAX_LEN must fit the 16-bit length field");
      if (MEM_AW < 1 || MEM_AW > 32)
         $error("MEM_AW out of range");
      if (FLAG_BIT < 0 || FLAG_BIT >= BYTE_W)
         $error("FLAG_BIT must index a data bit");
   endgenerate

   logic              byte_v, clr, sum_ok;
   logic [IMG_AW-1:0] idx, len;

   upl_ctl #(
      .MAX_LEN (MAX_LEN),
      .MEM_AW  (MEM_AW),
      .MEM_BASE(MEM_BASE),
      .FLAG_BIT(FLAG_BIT)
   ) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .bus_rdy  (bus_rdy),
      .bus_rdata(bus_rdata),
      .sum_ok   (sum_ok),
      .bus_addr (bus_addr),
      .bus_wr   (bus_wr),
      .bus_rd   (bus_rd),
      .bus_wdata(bus_wdata),
      .mem_we   (mem_we),
      .mem_addr (mem_addr),
      .mem_wdata(mem_wdata),
      .byte_v   (byte_v),
      .clr      (clr),
      .idx      (idx),
      .len      (len),
      .done     (done),
      .pass     (pass)
   );

   upl_sum u_sum (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .byte_v (byte_v),
      .byte_in(bus_rdata),
      .idx    (idx),
      .len    (len),
      .sum_ok (sum_ok)
   );
endmodule

// File: tb/sim_upl_engine.sv
module sim_upl_engine;
   localparam int CLK_P   = 10;
   localparam int MAXL    = 300;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  bus_addr, bus_wdata, bus_rdata, mem_wdata;
   logic        bus_wr, bus_rd, bus_rdy, mem_we, done, pass;
   logic [15:0] mem_addr;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   logic [7:0]  img [0:511];
   logic [15:0] pa = '0;
   int          flag_cnt = 0, flag_bad = 0;
   int          rd_cnt = 0;
   logic        lo_seen = 1'b0;
   logic        wait_mode = 1'b0;
   logic [23:0] exp_q [$];

   always #(CLK_P/2) clk = ~clk;

   upl_engine #(.MAX_LEN(MAXL)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .done(done), .pass(pass)
   );

   // module model: address register loaded by writes, data returned on read
   assign bus_rdata = img[pa[8:0]];

   always @(posedge clk) begin
      cyc++;
      if (bus_wr && bus_rdy) begin
         if (bus_addr == 8'h13) pa[7:0]  <= bus_wdata;
         if (bus_addr == 8'h14) pa[15:8] <= bus_wdata;
         if (bus_addr == 8'h10) begin
            flag_cnt++;
            if (bus_wdata != 8'h02) flag_bad++;
         end
      end
   end

   int rc = 0;
   always @(posedge clk) begin
      #1;
      rc++;
      bus_rdy = !(wait_mode && (rc % 3 == 1));
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: bus ordering and scoreboard of memory writes
   always @(negedge clk) begin
      if (rst_n) begin
         if (bus_wr && bus_rdy && bus_addr == 8'h13) lo_seen = 1'b1;
         if (bus_wr && bus_rdy && bus_addr == 8'h14) begin
            chk(lo_seen, "R1 hi after lo", lo_seen, 1);
            lo_seen = 1'b0;
         end
         if (bus_rd && bus_rdy) begin
            chk(bus_addr == 8'h11 && pa == 16'(rd_cnt), "R1 read index",
                pa, rd_cnt);
            rd_cnt++;
         end
         if (mem_we) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R3 unexpected mem write", mem_addr, 0);
            end else begin
               logic [23:0] e;
               e = exp_q.pop_front();
               chk({mem_addr, mem_wdata} == e, "R3 mem write",
                   {mem_addr, mem_wdata}, e);
            end
         end
      end
   end

   task automatic build(input int l, input bit bad_sum, input bit all_ff, input int seed);
      logic [15:0] s;
      s = 16'(l[7:0]) + 16'(l[15:8]);
      img[0] = l[7:0];
      img[1] = l[15:8];
      for (int k = 2; k < 512; k++) img[k] = 8'h00;
      for (int k = 2; k < l - 2 && k < 510; k++) begin
         img[k] = all_ff ? 8'hFF : 8'((k * 37 + seed) & 8'hFF);
         s = s + 16'(img[k]);
      end
      s = -s;
      if (bad_sum) s = s + 16'd1;
      if (l >= 4 && l <= 510) begin
         img[l-2] = s[7:0];
         img[l-1] = s[15:8];
      end
   endtask

   task automatic run(input int l, input bit exp_pass, input bit poke, input string req);
      int nread, tmo;
      bit seen;
      nread = (l < 4 || l > MAXL) ? 2 : l;
      exp_q.delete();
      for (int k = 0; k < nread; k++) exp_q.push_back({16'h7020 + 16'(k), img[k]});
      flag_cnt = 0; flag_bad = 0; rd_cnt = 0; lo_seen = 1'b0;
      @(posedge clk); #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      seen = 1'b0;
      fork
         begin
            if (poke) begin
               repeat (15) @(posedge clk);
               #1 start = 1'b1;
               @(posedge clk); #1 start = 1'b0;
            end
         end
         begin
            tmo = 0;
            while (!seen && tmo < 20000) begin
               @(negedge clk);
               tmo++;
               if (done) seen = 1'b1;
            end
         end
      join
      chk(seen, {req, " done seen"}, seen, 1);
      if (seen) begin
         chk(pass == exp_pass, {req, " pass"}, pass, exp_pass);
         chk(rd_cnt == nread, "R4 read count", rd_cnt, nread);
         chk(exp_q.size() == 0, "R3 all bytes stored", exp_q.size(), 0);
         chk(flag_cnt == (exp_pass ? 1 : 0) && flag_bad == 0, "R7 flag write",
             flag_cnt, exp_pass ? 1 : 0);
         @(negedge clk);
         chk(!done, "R8 done one cycle", done, 0);
         chk(pass == exp_pass, "R8 pass held", pass, exp_pass);
      end
      repeat (3) @(negedge clk);
      chk(rd_cnt == nread && !done, {req, " idle after done (R9)"}, rd_cnt, nread);
   endtask

   initial begin
      for (int k = 0; k < 512; k++) img[k] = 8'h00;
      repeat (3) @(posedge clk);
      #1;
      chk(!bus_wr && !bus_rd && !mem_we && !done, "R10 reset state",
          {bus_wr, bus_rd, mem_we, done}, 0);
      rst_n = 1'b1;

      build(6, 1'b0, 1'b0, 3);    run(6, 1'b1, 1'b0, "R6 len6");
      wait_mode = 1'b1;
      build(20, 1'b0, 1'b0, 9);   run(20, 1'b1, 1'b1, "R9 R2 len20 waits");
      build(20, 1'b1, 1'b0, 9);   run(20, 1'b0, 1'b0, "R6 bad sum");
      wait_mode = 1'b0;
      build(4, 1'b0, 1'b0, 0);    run(4, 1'b1, 1'b0, "R5 len4 min");
      build(3, 1'b0, 1'b0, 0);    run(3, 1'b0, 1'b0, "R5 len3");
      build(0, 1'b0, 1'b0, 0);    run(0, 1'b0, 1'b0, "R5 len0");
      build(MAXL + 1, 1'b0, 1'b0, 5); run(MAXL + 1, 1'b0, 1'b0, "R5 over max");
      build(MAXL, 1'b0, 1'b1, 0); run(MAXL, 1'b1, 1'b0, "R6 wrap max len");
      wait_mode = 1'b1;
      build(MAXL, 1'b1, 1'b1, 0); run(MAXL, 1'b0, 1'b0, "R6 wrap bad");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      wait (cyc > 150000);
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule